// File: doc/BRIEF.md
# SDRAM Software-Driven Command Issuer

This block sits between a host write port and the command pins of a single-data-rate SDRAM. It covers the device bring-up phase. Software does not rely on a hardware sequencer. It selects an action by placing a code on the mode input and then performs a write into the memory window. That write is consumed as a trigger: exactly one SDRAM command of the selected kind is driven, and the write is acknowledged afterwards. No data is transferred.

After reset, the block holds every SDRAM pin quiet for a programmable power-up pause. Host writes that arrive during the pause are stalled. The clock enable stays low until software issues its first no-operation command. The block also decodes bank bits from the host byte address using a small geometry configuration (column count, row count, bank count). These bank bits steer the mode-register and extended-mode-register loads. The extended load places the low-power fields on the address bus.

With the code at zero the block is in normal operation. It then only forwards a one-cycle accept strobe downstream. An "initialized" flag rises once a mode-register load has been issued and software has returned to normal operation.

Top module: `sdram_init_cmd`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs read as follows: `sdCke`=0, {`sdCsN`,`sdRasN`,`sdCasN`,`sdWeN`}=4'b1111, `sdBa`=0, `sdA`=0, `hostWrAck`=0, `normAccept`=0, `refreshCount`=0 and `initDone`=0.
- R2: For the first `PAUSE_CYCLES` clock cycles after reset, no SDRAM pin changes and no write is acknowledged. A write held pending during the pause is served once the pause ends, and its command appears no earlier than `PAUSE_CYCLES` cycles after reset release.
- R3: `sdCke` is 0 until the first no-operation command is driven. It rises in the same cycle as that command and never falls again.
- R4: Code 1 drives a no-operation command, pins 4'b0111, with `sdBa`=0 and `sdA`=0.
- R5: Code 2 drives a precharge of all banks, pins 4'b0010, with `sdA`[10]=1, every other `sdA` bit 0, and `sdBa`=0.
- R6: Code 4 drives an auto-refresh, pins 4'b0001, with `sdBa`=0 and `sdA`=0. Each one increments `refreshCount` in the cycle the command is visible, and the count saturates at its all-ones value (15 by default).
- R7: Code 3 drives a mode-register load, pins 4'b0000. `sdBa` carries the decoded bank bits and `sdA`[11:0] = `hostAddr`[12:1], with the upper `sdA` bits 0.
- R8: Code 5 drives an extended-mode-register load, pins 4'b0000. `sdBa` carries the decoded bank bits and `sdA` = {0, `lpDrive`[1:0] at bits 6:5, `lpTempComp`[1:0] at bits 4:3, `lpArrayPart`[2:0] at bits 2:0}.
- R9: Bank bits start at byte-address bit 1+(8+`cfgColCode`)+(11+`cfgRowCode`), which covers a 16-bit bus. With `cfgFourBanks`=1 two bits are taken. With `cfgFourBanks`=0 one bit is taken and `sdBa`[1]=0. For example, with 9 columns, 12 rows and 4 banks, offset 0x800000 gives bank 2.
- R10: A command is visible on the pins for exactly one cycle. `hostWrAck` is high in the following cycle, and at that point the pins are back to no-operation, 4'b0111.
- R11: Code 0 drives no command. The write is acknowledged in the cycle after it is taken, with `normAccept`=1 in that cycle. Codes 6 and 7 also drive no command and are acknowledged the same way, but with `normAccept`=0.
- R12: `initDone` rises in the cycle after a clock edge at which the code is 0 and a mode-register load has already been issued. Once high, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rstN | input | 1 | Active-low synchronous reset |
| cfgModeCode | input | 3 | Software action code (0 normal, 1 NOP, 2 precharge all, 3 mode load, 4 refresh, 5 extended load) |
| cfgColCode | input | 2 | Column address bits minus 8 |
| cfgRowCode | input | 2 | Row address bits minus 11 |
| cfgFourBanks | input | 1 | 1 = four banks, 0 = two banks |
| lpArrayPart | input | 3 | Partial-array self-refresh field |
| lpTempComp | input | 2 | Temperature-compensated self-refresh field |
| lpDrive | input | 2 | Output drive-strength field |
| hostWrValid | input | 1 | Host write into the SDRAM window, held until acknowledged |
| hostAddr | input | ADDR_W | Byte offset of the write within the window |
| hostWrAck | output | 1 | One-cycle write acknowledge |
| normAccept | output | 1 | One-cycle accept strobe for normal-mode writes |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdA | output | A_W | Multiplexed address bus |
| refreshCount | output | REF_W | Saturating count of auto-refresh commands issued |
| initDone | output | 1 | Initialization-complete flag |

## Verification
The main function is driven with the full bring-up order: no-operation, precharge, eight refreshes, mode load and extended load. Each step uses a different code and a different host address, so a wrong code-to-pin mapping, a wrong bit for A10, or mixed-up mode and extended loads each give a distinct pin or address mismatch. Several bank-geometry settings are tried with addresses whose bits lie just above and below the decoded bank field. This separates a wrong shift distance from a wrong bank-width choice. A write held pending from inside the power-up pause shows whether the stall respects the cycle count. Normal and reserved codes confirm that no command leaks onto the pins and that the accept strobe goes only to code 0.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PRECH  = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_REF    = 3'd4,
    MODE_LEMR   = 3'd5
  } modeCode_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MRS   = 4'b0000;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadCmd;
    modeCode_e cmdMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PAUSE_CYCLES = 26667
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeCode,
  input  logic        hostWrValid,
  output logic        hostWrAck,
  output logic        normAccept,
  output logic        pauseDone,
  output ctrlStrobe_t strobe
);

  localparam int PAUSE_W = $clog2(PAUSE_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DRIVE, ST_ACK} state_e;

  state_e             state;
  logic [PAUSE_W-1:0] pauseCnt;
  logic               normFlag;
  logic               start;
  logic               isCmd;

  // power-up pause: counts clock cycles after reset release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCnt  <= '0;
      pauseDone <= 1'b0;
    end else if (!pauseDone) begin
      if (pauseCnt == PAUSE_W'(PAUSE_CYCLES - 1)) pauseDone <= 1'b1;
      else                                        pauseCnt  <= pauseCnt + 1'b1;
    end
  end

  always_comb begin
    isCmd = (modeCode >= 3'd1) && (modeCode <= 3'd5);
    start = (state == ST_IDLE) && hostWrValid && pauseDone;
    strobe.loadCmd = start && isCmd;
    strobe.cmdMode = modeCode_e'(modeCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      normFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= isCmd ? ST_DRIVE : ST_ACK;
          normFlag <= (modeCode == 3'd0);
        end
        ST_DRIVE: state <= ST_ACK;
        ST_ACK:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign hostWrAck  = (state == ST_ACK);
  assign normAccept = (state == ST_ACK) && normFlag;

endmodule

// File: rtl/sdram_init_bankmap.sv
module sdram_init_bankmap #(
  parameter int ADDR_W    = 28,
  parameter int BUS_SHIFT = 1
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        colCode,
  input  logic [1:0]        rowCode,
  input  logic              fourBanks,
  output logic [1:0]        bank
);

  localparam int COL_BASE = 8;
  localparam int ROW_BASE = 11;
  localparam int FIXED    = BUS_SHIFT + COL_BASE + ROW_BASE;

  logic [5:0]        bankPos;
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    bankPos = 6'(FIXED) + 6'(colCode) + 6'(rowCode);
    shifted = hostAddr >> bankPos;
    bank    = fourBanks ? shifted[1:0] : {1'b0, shifted[0]};
  end

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int A_W       = 13,
  parameter int REF_W     = 4,
  parameter int BUS_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        modeCode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        colCode,
  input  logic [1:0]        rowCode,
  input  logic              fourBanks,
  input  logic [2:0]        lpArrayPart,
  input  logic [1:0]        lpTempComp,
  input  logic [1:0]        lpDrive,
  output logic              sdCke,
  output logic [3:0]        sdCmd,
  output logic [1:0]        sdBa,
  output logic [A_W-1:0]    sdA,
  output logic [REF_W-1:0]  refreshCount,
  output logic              initDone
);

  localparam int MR_W = 12;
  localparam int A10  = 10;

  logic [1:0]     bankSel;
  logic [MR_W-1:0] mrValue;
  logic [A_W-1:0] lpValue;
  logic [3:0]     idleCmd;
  logic           mrsSeen;

  sdram_init_bankmap #(
    .ADDR_W   (ADDR_W),
    .BUS_SHIFT(BUS_SHIFT)
  ) uBankMap (
    .hostAddr (hostAddr),
    .colCode  (colCode),
    .rowCode  (rowCode),
    .fourBanks(fourBanks),
    .bank     (bankSel)
  );

  always_comb begin
    mrValue = hostAddr[BUS_SHIFT +: MR_W];
    lpValue = A_W'({lpDrive, lpTempComp, lpArrayPart});
    idleCmd = sdCke ? CMD_NOP : CMD_DESEL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCke        <= 1'b0;
      sdCmd        <= CMD_DESEL;
      sdBa         <= '0;
      sdA          <= '0;
      refreshCount <= '0;
      mrsSeen      <= 1'b0;
      initDone     <= 1'b0;
    end else begin
      initDone <= initDone | (mrsSeen && (modeCode == 3'd0));
      if (strobe.loadCmd) begin
        sdBa <= '0;
        sdA  <= '0;
        unique case (strobe.cmdMode)
          MODE_NOP: begin
            sdCmd <= CMD_NOP;
            sdCke <= 1'b1;
          end
          MODE_PRECH: begin
            sdCmd <= CMD_PRE;
            sdA   <= A_W'(1) << A10;
          end
          MODE_REF: begin
            sdCmd <= CMD_REF;
            if (refreshCount != '1) refreshCount <= refreshCount + 1'b1;
          end
          MODE_LMR: begin
            sdCmd   <= CMD_MRS;
            sdBa    <= bankSel;
            sdA     <= A_W'(mrValue);
            mrsSeen <= 1'b1;
          end
          MODE_LEMR: begin
            sdCmd <= CMD_MRS;
            sdBa  <= bankSel;
            sdA   <= lpValue;
          end
          default: sdCmd <= idleCmd;
        endcase
      end else begin
        sdCmd <= idleCmd;
        sdBa  <= '0;
        sdA   <= '0;
      end
    end
  end

endmodule

// File: rtl/sdram_init_cmd.sv
module sdram_init_cmd
  import sdram_init_pkg::*;
#(
  parameter int PAUSE_CYCLES = 26667,
  parameter int ADDR_W       = 28,
  parameter int A_W          = 13,
  parameter int REF_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgModeCode,
  input  logic [1:0]        cfgColCode,
  input  logic [1:0]        cfgRowCode,
  input  logic              cfgFourBanks,
  input  logic [2:0]        lpArrayPart,
  input  logic [1:0]        lpTempComp,
  input  logic [1:0]        lpDrive,
  input  logic              hostWrValid,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hostWrAck,
  output logic              normAccept,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [1:0]        sdBa,
  output logic [A_W-1:0]    sdA,
  output logic [REF_W-1:0]  refreshCount,
  output logic              initDone
);

  localparam int BUS_SHIFT = 1;  // 16-bit data bus

  ctrlStrobe_t strobe;
  logic        pauseDone;
  logic [3:0]  sdCmd;

  sdram_init_ctrl #(.PAUSE_CYCLES(PAUSE_CYCLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeCode   (cfgModeCode),
    .hostWrValid(hostWrValid),
    .hostWrAck  (hostWrAck),
    .normAccept (normAccept),
    .pauseDone  (pauseDone),
    .strobe     (strobe)
  );

  sdram_init_dp #(
    .ADDR_W   (ADDR_W),
    .A_W      (A_W),
    .REF_W    (REF_W),
    .BUS_SHIFT(BUS_SHIFT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .modeCode    (cfgModeCode),
    .hostAddr    (hostAddr),
    .colCode     (cfgColCode),
    .rowCode     (cfgRowCode),
    .fourBanks   (cfgFourBanks),
    .lpArrayPart (lpArrayPart),
    .lpTempComp  (lpTempComp),
    .lpDrive     (lpDrive),
    .sdCke       (sdCke),
    .sdCmd       (sdCmd),
    .sdBa        (sdBa),
    .sdA         (sdA),
    .refreshCount(refreshCount),
    .initDone    (initDone)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = sdCmd;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int A_W   = 13,
  parameter int REF_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pauseDone,
  input logic [2:0]       cfgModeCode,
  input logic             hostWrAck,
  input logic             normAccept,
  input logic             sdCke,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [A_W-1:0]   sdA,
  input logic [REF_W-1:0] refreshCount,
  input logic             initDone
);

  logic [3:0] pins;
  assign pins = {sdCsN, sdRasN, sdCasN, sdWeN};

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> (pins == 4'b1111 && !sdCke && !hostWrAck));

  a_r3_cke_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sdCke |=> sdCke);

  a_r5_precharge_a10: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0010) |-> sdA[10]);

  a_r6_count_on_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCount != $past(refreshCount)) |-> (pins == 4'b0001));

  a_r10_ack_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && {sdRasN, sdCasN, sdWeN} != 3'b111) |=> (hostWrAck && pins == 4'b0111));

  a_r11_accept_only_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    normAccept |-> hostWrAck);

  a_r12_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r12_init_needs_normal: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> ($past(cfgModeCode) == 3'd0));

endmodule

bind sdram_init_cmd sdram_init_chk #(.A_W(A_W), .REF_W(REF_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .pauseDone   (pauseDone),
  .cfgModeCode (cfgModeCode),
  .hostWrAck   (hostWrAck),
  .normAccept  (normAccept),
  .sdCke       (sdCke),
  .sdCsN       (sdCsN),
  .sdRasN      (sdRasN),
  .sdCasN      (sdCasN),
  .sdWeN       (sdWeN),
  .sdA         (sdA),
  .refreshCount(refreshCount),
  .initDone    (initDone)
);

// File: tb/sdram_init_cmd_test.sv
module sdram_init_cmd_test;

  localparam int PAUSE  = 40;
  localparam int ADDR_W = 28;
  localparam int A_W    = 13;
  localparam int REF_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        cfgModeCode = 3'd0;
  logic [1:0]        cfgColCode = 2'd1;
  logic [1:0]        cfgRowCode = 2'd1;
  logic              cfgFourBanks = 1'b1;
  logic [2:0]        lpArrayPart = 3'd1;
  logic [1:0]        lpTempComp = 2'd2;
  logic [1:0]        lpDrive = 2'd1;
  logic              hostWrValid = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic              hostWrAck, normAccept, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]        sdBa;
  logic [A_W-1:0]    sdA;
  logic [REF_W-1:0]  refreshCount;
  logic              initDone;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  sdram_init_cmd #(
    .PAUSE_CYCLES(PAUSE), .ADDR_W(ADDR_W), .A_W(A_W), .REF_W(REF_W)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgModeCode(cfgModeCode), .cfgColCode(cfgColCode),
    .cfgRowCode(cfgRowCode), .cfgFourBanks(cfgFourBanks), .lpArrayPart(lpArrayPart),
    .lpTempComp(lpTempComp), .lpDrive(lpDrive), .hostWrValid(hostWrValid),
    .hostAddr(hostAddr), .hostWrAck(hostWrAck), .normAccept(normAccept),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdA(sdA), .refreshCount(refreshCount), .initDone(initDone)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [27:0] addr;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] a;
  } vec_t;

  // bring-up order; geometry 9 col / 12 row / 4 banks, lp fields ds=1 tcsr=2 pasr=1
  localparam vec_t SEQ [12] = '{
    '{3'd1, 28'h0000000, 4'b0111, 2'd0, 13'h000},
    '{3'd2, 28'h0001234, 4'b0010, 2'd0, 13'h400},
    '{3'd4, 28'h0000010, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000020, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000030, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000040, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000050, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000060, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000070, 4'b0001, 2'd0, 13'h000},
    '{3'd4, 28'h0000080, 4'b0001, 2'd0, 13'h000},
    '{3'd3, 28'h0000060, 4'b0000, 2'd0, 13'h030},
    '{3'd5, 28'h0800000, 4'b0000, 2'd2, 13'h031}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  // one triggered write: command visible one cycle, ack the next
  task automatic doWrite(input logic [2:0] mode, input logic [27:0] addr,
                         input logic [3:0] eCmd, input logic [1:0] eBa,
                         input logic [12:0] eA, input string req);
    @(negedge clk);
    cfgModeCode = mode;
    hostAddr    = addr;
    hostWrValid = 1'b1;
    @(negedge clk);
    chk({req, " cmd pins"}, 32'(pins()), 32'(eCmd));
    chk({req, " bank"}, 32'(sdBa), 32'(eBa));
    chk({req, " addr bus"}, 32'(sdA), 32'(eA));
    chk({req, " R10 no early ack"}, 32'(hostWrAck), 32'd0);
    @(negedge clk);
    chk({req, " R10 ack"}, 32'(hostWrAck), 32'd1);
    chk({req, " R10 pins idle"}, 32'(pins()), 32'h7);
    hostWrValid = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    int waitCycles;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cke", 32'(sdCke), 32'd0);
    chk("R1 pins", 32'(pins()), 32'hF);
    chk("R1 ba/a", 32'({sdBa, sdA}), 32'd0);
    chk("R1 ack", 32'({hostWrAck, normAccept}), 32'd0);
    chk("R1 count/init", 32'({refreshCount, initDone}), 32'd0);
    rstN = 1'b1;
    waitCycles = 0;

    // R2 / R3: quiet pause, then a write raised mid-pause stalls
    repeat (PAUSE / 2) begin
      @(negedge clk);
      waitCycles++;
    end
    cfgModeCode = 3'd1;
    hostAddr    = '0;
    hostWrValid = 1'b1;
    while (pins() == 4'hF && waitCycles < PAUSE + 10) begin
      if (sdCke !== 1'b0 || hostWrAck !== 1'b0)
        chk("R2 R3 quiet during pause", 32'({sdCke, hostWrAck}), 32'd0);
      @(negedge clk);
      waitCycles++;
    end
    nChecks++;
    if (waitCycles < PAUSE || waitCycles > PAUSE + 2) begin
      nFail++;
      $display("FAIL R2 pause length actual=%0d expected=%0d..%0d", waitCycles, PAUSE, PAUSE + 2);
    end
    chk("R4 first NOP pins", 32'(pins()), 32'h7);
    chk("R3 cke rises with NOP", 32'(sdCke), 32'd1);
    @(negedge clk);
    chk("R10 ack after first NOP", 32'(hostWrAck), 32'd1);
    hostWrValid = 1'b0;

    // table: full bring-up (R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 12; i++)
      doWrite(SEQ[i].mode, SEQ[i].addr, SEQ[i].cmd, SEQ[i].ba, SEQ[i].a,
              $sformatf("R4-R8 step%0d", i));
    chk("R6 eight refreshes", 32'(refreshCount), 32'd8);
    chk("R12 not yet init", 32'(initDone), 32'd0);
    chk("R3 cke held", 32'(sdCke), 32'd1);

    // R11 normal mode and R12
    @(negedge clk);
    cfgModeCode = 3'd0;
    hostAddr    = 28'h0000100;
    hostWrValid = 1'b1;
    @(negedge clk);
    chk("R11 normal ack", 32'(hostWrAck), 32'd1);
    chk("R11 normal accept", 32'(normAccept), 32'd1);
    chk("R11 no command", 32'(pins()), 32'h7);
    chk("R12 init done", 32'(initDone), 32'd1);
    hostWrValid = 1'b0;

    // R11 reserved code
    @(negedge clk);
    cfgModeCode = 3'd6;
    hostWrValid = 1'b1;
    @(negedge clk);
    chk("R11 reserved ack", 32'(hostWrAck), 32'd1);
    chk("R11 reserved no accept", 32'(normAccept), 32'd0);
    chk("R11 reserved no command", 32'(pins()), 32'h7);
    hostWrValid = 1'b0;

    // R9 bank decode under other geometries
    cfgColCode = 2'd0; cfgRowCode = 2'd0; cfgFourBanks = 1'b0;
    doWrite(3'd3, 28'h0300000, 4'b0000, 2'd1, 13'h000, "R9 2bank pos20");
    doWrite(3'd3, 28'h00FFFFE, 4'b0000, 2'd0, 13'hFFF, "R9 R7 below bank");
    cfgColCode = 2'd2; cfgRowCode = 2'd2; cfgFourBanks = 1'b1;
    doWrite(3'd5, 28'h3000000, 4'b0000, 2'd3, 13'h031, "R9 R8 4bank pos24");
    cfgColCode = 2'd1; cfgRowCode = 2'd1;
    doWrite(3'd3, 28'h0400000, 4'b0000, 2'd1, 13'h000, "R9 4bank pos22");
    chk("R12 init stays", 32'(initDone), 32'd1);

    // R6 saturation
    for (int i = 0; i < 8; i++)
      doWrite(3'd4, 28'h0, 4'b0001, 2'd0, 13'h000, "R6 extra refresh");
    chk("R6 saturated", 32'(refreshCount), 32'd15);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule